// File: doc/BRIEF.md
# Six-Source Interrupt Aggregator with Set/Clear Masking

This block gathers interrupt events from six peripheral sources into one read-only pending register. It combines that register with a programmable enable mask to drive a single level-sensitive interrupt line toward the CPU. Software changes the mask through write-only set/clear bit pairs, so it never needs a read-modify-write. Each pending bit is cleared as a side effect of a write to a register that belongs to its own peripheral. The block decodes those writes from the same simple register bus that reaches the pending and mask registers.

The bus has an address, write data, a write strobe and a combinational read-data return. Event inputs are single-cycle pulses from the peripherals. The audio event marks the start of an audio DMA transfer, not its completion. The CPU line stays high as long as any enabled source is pending.

Source bit order in every register: bit 0 signal processor, bit 1 serial link, bit 2 audio, bit 3 video, bit 4 parallel link, bit 5 display processor. Byte addresses: 0x00 display mode, 0x04 mask, 0x08 pending, 0x10 video current line, 0x14 audio status, 0x18 parallel status, 0x1C serial status, 0x20 signal-processor status.

Top module: `irq_hub`

## Requirements
- R1: A pulse on evtIn[n] sets pending bit n at the next clock edge. Reading address 0x08 returns the pending bits in rdData[5:0] and zeros in rdData[31:6].
- R2: A write to address 0x08 does not change the pending register.
- R3: A write to address 0x04 with data bit 2n+1 = 1 and bit 2n = 0 sets mask bit n. With bit 2n = 1 and bit 2n+1 = 0 it clears mask bit n. With both bits 0, mask bit n is unchanged.
- R4: A write to address 0x04 with both data bits 2n and 2n+1 equal to 1 leaves mask bit n unchanged.
- R5: Reading address 0x04 returns the mask in rdData[5:0] and zeros in rdData[31:6].
- R6: Any write to address 0x10 clears the video pending bit (bit 3).
- R7: A write to address 0x00 with data bit 11 = 1 clears the display pending bit (bit 5). With bit 11 = 0 the write has no effect on pending.
- R8: A write to address 0x18 with data bit 1 = 1 clears the parallel pending bit (bit 4). With bit 1 = 0 it has no effect.
- R9: evtIn[2] is the audio DMA-start event and sets pending bit 2. Any write to address 0x14 clears that bit.
- R10: Any write to address 0x1C clears the serial pending bit (bit 1). A write to address 0x20 with data bit 3 = 1 clears the signal-processor pending bit (bit 0), and with bit 3 = 0 it has no effect.
- R11: cpuIrq is registered. After each clock edge it equals the OR over all sources of (pending AND mask) as those registers held before that edge.
- R12: When an event and a clearing write hit the same source in the same cycle, the pending bit ends up set.
- R13: After reset, pending and mask are zero and cpuIrq is low. Reads of any address other than 0x04 and 0x08 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wrData | input | 32 | Write data |
| evtIn | input | 6 | Single-cycle event pulses, one per source |
| rdData | output | 32 | Read data for addr (combinational) |
| cpuIrq | output | 1 | Level interrupt line to the CPU |

## Verification
Directed sequences first raise every source and then clear the sources one at a time. Each clearing register is written with its qualifying bit both absent and present, which separates a correct bit-qualified decode from an address-only decode. Mask writes use set-only, clear-only and both-bits patterns, which tell the hold rule apart from "set wins" or "clear wins". A raise collides with its own clearing write to expose the priority, and the line is sampled one and two cycles after a mask change to pin the register latency. A long run of seeded random writes over all mapped and unmapped addresses, mixed with sparse random events, is compared each cycle against a bench model of the pending, mask and line state.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NUM_SRC = 6;
  localparam int SRC_SP  = 0;
  localparam int SRC_SER = 1;
  localparam int SRC_AUD = 2;
  localparam int SRC_VID = 3;
  localparam int SRC_PAR = 4;
  localparam int SRC_DSP = 5;

  typedef enum logic [1:0] {RD_ZERO, RD_MASK, RD_PEND} rdSel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] pendClr;
    logic [NUM_SRC-1:0] maskClr;
    logic [NUM_SRC-1:0] maskSet;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADR_MODE  = 8'h00,
  parameter logic [ADDR_W-1:0] ADR_MASK  = 8'h04,
  parameter logic [ADDR_W-1:0] ADR_PEND  = 8'h08,
  parameter logic [ADDR_W-1:0] ADR_VLINE = 8'h10,
  parameter logic [ADDR_W-1:0] ADR_ASTAT = 8'h14,
  parameter logic [ADDR_W-1:0] ADR_PSTAT = 8'h18,
  parameter logic [ADDR_W-1:0] ADR_SSTAT = 8'h1C,
  parameter logic [ADDR_W-1:0] ADR_SPSTAT = 8'h20,
  parameter int DSP_CLR_BIT = 11,
  parameter int PAR_CLR_BIT = 1,
  parameter int SP_CLR_BIT  = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrb_t         strb,
  output rdSel_e            rdSel
);
  logic               maskHit;
  logic [NUM_SRC-1:0] maskClrV;
  logic [NUM_SRC-1:0] maskSetV;
  logic [NUM_SRC-1:0] pendClrV;

  assign maskHit = wrEn && (addr == ADR_MASK);

  // one set/clear pair per source; both bits high means hold
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPair
    assign maskClrV[g] = maskHit &&  wrData[2*g] && !wrData[2*g+1];
    assign maskSetV[g] = maskHit && !wrData[2*g] &&  wrData[2*g+1];
  end

  always_comb begin
    pendClrV          = '0;
    pendClrV[SRC_VID] = wrEn && (addr == ADR_VLINE);
    pendClrV[SRC_AUD] = wrEn && (addr == ADR_ASTAT);
    pendClrV[SRC_SER] = wrEn && (addr == ADR_SSTAT);
    pendClrV[SRC_DSP] = wrEn && (addr == ADR_MODE)   && wrData[DSP_CLR_BIT];
    pendClrV[SRC_PAR] = wrEn && (addr == ADR_PSTAT)  && wrData[PAR_CLR_BIT];
    pendClrV[SRC_SP]  = wrEn && (addr == ADR_SPSTAT) && wrData[SP_CLR_BIT];
  end

  always_comb begin
    strb.pendClr = pendClrV;
    strb.maskClr = maskClrV;
    strb.maskSet = maskSetV;
  end

  always_comb begin
    if (addr == ADR_MASK)      rdSel = RD_MASK;
    else if (addr == ADR_PEND) rdSel = RD_PEND;
    else                       rdSel = RD_ZERO;
  end
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  ctrlStrb_t          strb,
  input  rdSel_e             rdSel,
  output logic [DATA_W-1:0]  rdData,
  output logic               cpuIrq,
  output logic [NUM_SRC-1:0] pendQ,
  output logic [NUM_SRC-1:0] maskQ
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    // a raise outranks a clear so no event is dropped
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 pendQ[g] <= 1'b0;
      else if (evtIn[g])         pendQ[g] <= 1'b1;
      else if (strb.pendClr[g])  pendQ[g] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 maskQ[g] <= 1'b0;
      else if (strb.maskSet[g])  maskQ[g] <= 1'b1;
      else if (strb.maskClr[g])  maskQ[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrq <= 1'b0;
    else       cpuIrq <= |(pendQ & maskQ);
  end

  always_comb begin
    unique case (rdSel)
      RD_MASK: rdData = {{PAD_W{1'b0}}, maskQ};
      RD_PEND: rdData = {{PAD_W{1'b0}}, pendQ};
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADR_MODE   = 8'h00,
  parameter logic [ADDR_W-1:0] ADR_MASK   = 8'h04,
  parameter logic [ADDR_W-1:0] ADR_PEND   = 8'h08,
  parameter logic [ADDR_W-1:0] ADR_VLINE  = 8'h10,
  parameter logic [ADDR_W-1:0] ADR_ASTAT  = 8'h14,
  parameter logic [ADDR_W-1:0] ADR_PSTAT  = 8'h18,
  parameter logic [ADDR_W-1:0] ADR_SSTAT  = 8'h1C,
  parameter logic [ADDR_W-1:0] ADR_SPSTAT = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [5:0]        evtIn,
  output logic [DATA_W-1:0] rdData,
  output logic              cpuIrq
);
  ctrlStrb_t          strb;
  rdSel_e             rdSel;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] maskQ;

  irq_hub_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADR_MODE(ADR_MODE), .ADR_MASK(ADR_MASK), .ADR_PEND(ADR_PEND),
    .ADR_VLINE(ADR_VLINE), .ADR_ASTAT(ADR_ASTAT), .ADR_PSTAT(ADR_PSTAT),
    .ADR_SSTAT(ADR_SSTAT), .ADR_SPSTAT(ADR_SPSTAT)
  ) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .strb(strb), .rdSel(rdSel)
  );

  irq_hub_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb), .rdSel(rdSel),
    .rdData(rdData), .cpuIrq(cpuIrq), .pendQ(pendQ), .maskQ(maskQ)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] ADR_MASK = 8'h04,
  parameter logic [ADDR_W-1:0] ADR_PEND = 8'h08
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [5:0]        evtIn,
  input logic              cpuIrq,
  input logic [5:0]        pendQ,
  input logic [5:0]        maskQ
);
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (cpuIrq == $past(|(pendQ & maskQ)))); // R11

  AST_RAISE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((pendQ & $past(evtIn)) == $past(evtIn))); // R12

  AST_PEND_READONLY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_PEND && evtIn == 6'd0) |=> (pendQ == $past(pendQ))); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_MASK && wrData[1:0] == 2'b11) |=> (maskQ[0] == $past(maskQ[0]))); // R4

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADR_MASK) |=> $stable(maskQ)); // R3
endmodule

bind irq_hub irq_hub_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADR_MASK(ADR_MASK), .ADR_PEND(ADR_PEND)
) u_chk (.*);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;
  localparam logic [7:0] A_MODE = 8'h00, A_MASK = 8'h04, A_PEND = 8'h08,
    A_VLINE = 8'h10, A_ASTAT = 8'h14, A_PSTAT = 8'h18, A_SSTAT = 8'h1C,
    A_SPST = 8'h20, A_NONE = 8'h3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [5:0]  evtIn = '0;
  logic [31:0] rdData;
  logic        cpuIrq;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_hub u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
              .wrData(wrData), .evtIn(evtIn), .rdData(rdData), .cpuIrq(cpuIrq));

  // reference model built from the requirements
  logic [5:0] pendM, maskM;
  logic       irqM;

  function automatic logic [5:0] expClr(logic w, logic [7:0] a, logic [31:0] d);
    logic [5:0] c = '0;
    if (w) begin
      if (a == A_SPST  && d[3])  c[0] = 1'b1; // R10
      if (a == A_SSTAT)          c[1] = 1'b1; // R10
      if (a == A_ASTAT)          c[2] = 1'b1; // R9
      if (a == A_VLINE)          c[3] = 1'b1; // R6
      if (a == A_PSTAT && d[1])  c[4] = 1'b1; // R8
      if (a == A_MODE  && d[11]) c[5] = 1'b1; // R7
    end
    return c;
  endfunction

  function automatic logic [5:0] expMask(logic [5:0] m, logic w, logic [7:0] a, logic [31:0] d);
    logic [5:0] r = m;
    if (w && a == A_MASK)
      for (int n = 0; n < 6; n++) begin
        if (d[2*n+1] && !d[2*n]) r[n] = 1'b1;
        else if (d[2*n] && !d[2*n+1]) r[n] = 1'b0;
      end
    return r;
  endfunction

  function automatic logic [31:0] expRd(logic [7:0] a);
    if (a == A_MASK) return {26'd0, maskM};
    if (a == A_PEND) return {26'd0, pendM};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pendM <= '0; maskM <= '0; irqM <= 1'b0;
    end else begin
      irqM  <= |(pendM & maskM);
      pendM <= (pendM & ~expClr(wrEn, addr, wrData)) | evtIn;
      maskM <= expMask(maskM, wrEn, addr, wrData);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic w, logic [7:0] a, logic [31:0] d, logic [5:0] e);
    @(negedge clk);
    wrEn = w; addr = a; wrData = d; evtIn = e;
  endtask

  // idle cycle after the previous drive, then look at a register
  task automatic look(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    wrEn = 1'b0; evtIn = '0; wrData = '0; addr = a;
    #1 check(tag, rdData, exp);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R13 reset state
    look("R13 pending after reset", A_PEND, 32'h0);
    check("R13 irq after reset", {31'd0, cpuIrq}, 32'd0);
    look("R13 mask after reset", A_MASK, 32'h0);
    look("R13 unmapped read", A_NONE, 32'h0);

    // R1 raise all
    drive(1'b0, A_PEND, 32'h0, 6'h3F);
    look("R1 all raised", A_PEND, 32'h3F);
    // R2 pending write ignored
    drive(1'b1, A_PEND, 32'hFFFF_FFFF, 6'h0);
    look("R2 pend write ignored", A_PEND, 32'h3F);
    check("R11 irq low with mask zero", {31'd0, cpuIrq}, 32'd0);

    // R3 set all mask bits, R5 readback, R11 latency
    drive(1'b1, A_MASK, 32'hFFFF_FAAA, 6'h0);
    look("R5 mask readback", A_MASK, 32'h3F);
    check("R11 irq one edge after mask", {31'd0, cpuIrq}, 32'd0);
    look("R3 mask still set", A_MASK, 32'h3F);
    check("R11 irq two edges after mask", {31'd0, cpuIrq}, 32'd1);

    // R4 both bits hold, R3 clear
    drive(1'b1, A_MASK, 32'h0000_0003, 6'h0);
    look("R4 both bits hold", A_MASK, 32'h3F);
    drive(1'b1, A_MASK, 32'h0000_0001, 6'h0);
    look("R3 clear-only bit", A_MASK, 32'h3E);
    drive(1'b1, A_MASK, 32'h0000_0002, 6'h0);
    look("R3 set-only bit", A_MASK, 32'h3F);

    // R7 display
    drive(1'b1, A_MODE, 32'h0000_07FF, 6'h0);
    look("R7 mode without bit 11", A_PEND, 32'h3F);
    drive(1'b1, A_MODE, 32'h0000_0800, 6'h0);
    look("R7 mode with bit 11", A_PEND, 32'h1F);
    // R8 parallel
    drive(1'b1, A_PSTAT, 32'hFFFF_FFFD, 6'h0);
    look("R8 status without bit 1", A_PEND, 32'h1F);
    drive(1'b1, A_PSTAT, 32'h0000_0002, 6'h0);
    look("R8 status with bit 1", A_PEND, 32'h0F);
    // R6 video
    drive(1'b1, A_VLINE, 32'h0, 6'h0);
    look("R6 video line write", A_PEND, 32'h07);
    // R12 collision, R9 audio
    drive(1'b1, A_ASTAT, 32'h0, 6'h04);
    look("R12 raise beats clear", A_PEND, 32'h07);
    drive(1'b1, A_ASTAT, 32'h0, 6'h0);
    look("R9 audio status write", A_PEND, 32'h03);
    drive(1'b0, A_PEND, 32'h0, 6'h04);
    look("R9 audio DMA start event", A_PEND, 32'h07);
    drive(1'b1, A_ASTAT, 32'h1234, 6'h0);
    look("R9 audio cleared again", A_PEND, 32'h03);
    // R10 serial and signal processor
    drive(1'b1, A_SSTAT, 32'h0, 6'h0);
    look("R10 serial status write", A_PEND, 32'h01);
    drive(1'b1, A_SPST, 32'hFFFF_FFF7, 6'h0);
    look("R10 sp without bit 3", A_PEND, 32'h01);
    drive(1'b1, A_SPST, 32'h0000_0008, 6'h0);
    look("R10 sp with bit 3", A_PEND, 32'h00);
    look("R11 irq drops", A_PEND, 32'h00);
    check("R11 irq low after clears", {31'd0, cpuIrq}, 32'd0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] pick [9];
      pick = '{A_MODE, A_MASK, A_PEND, A_VLINE, A_ASTAT, A_PSTAT, A_SSTAT, A_SPST, A_NONE};
      @(negedge clk);
      #1;
      check("R11 random irq", {31'd0, cpuIrq}, {31'd0, irqM});
      check("R1 R5 random read", rdData, expRd(addr));
      wrEn   = ($urandom % 3) != 0;
      addr   = pick[$urandom % 9];
      wrData = $urandom;
      evtIn  = (($urandom % 6) == 0) ? 6'($urandom) : 6'd0;
    end
    @(negedge clk);
    wrEn = 1'b0; evtIn = '0;
    #1 check("R11 final irq", {31'd0, cpuIrq}, {31'd0, irqM});

    done = 1;
    summary();
    $finish;
  end
endmodule